// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit sits beside a processor's control path and, whenever the core offers it an interrupt request, decides in a single cycle whether that interrupt is accepted. A request is accepted only if all three of these hold:

- its level lies above the interrupt level currently recorded in the status word;
- its level lies inside the configured range of levels;
- at least one interrupt line of that level is both raised and enabled.

When the request is accepted, the unit writes the new status word and redirects the program counter. It also records the return address and status in the save register that belongs to the level being taken.

Levels above one are dispatched directly. Each such level has its own vector and its own pair of return-address and saved-status registers. Level one has no vector of its own. It is reported as an exception whose cause code names a level-one interrupt. It goes to the kernel or the user exception vector, or to the double-exception vector if an exception is already being handled. Every vector address can be moved by a run-time base address, or the default base can be kept.

The core feeds the current status word and program counter every cycle. The unit returns them unchanged when nothing is taken, and returns the dispatch values together with a one-cycle taken pulse when something is.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken only when all of the following hold in the same cycle: `irq_req` is high; `irq_level` is greater than `ps_in[3:0]` (the interrupt-level field); `irq_level` is at most NLEVEL (6); and `level_masks[(irq_level-1)*NINT +: NINT] & int_raised & int_enabled` is nonzero.
- R2: When a level L of 2 or more is taken, `pc_in` is stored into `epc_out[(L-1)*32 +: 32]` and `ps_in` into `eps_out[(L-2)*32 +: 32]`; no other save slot changes.
- R3: When a level L of 2 or more is taken, `ps_out` equals `ps_in` with bits [3:0] replaced by L and bit 4 (exception-mode flag) set, and `pc_out` is the level vector at offset 0x180 + (L-2)*0x40.
- R4: When level 1 is taken, `exc_cause` becomes 4, and `ps_out` equals `ps_in` with bit 4 set and all other bits kept.
- R5: When level 1 is taken while `ps_in[4]` is set, `pc_out` is the double-exception vector (offset 0x3C0), `pc_in` is saved in `depc_out`, and the level-1 slot of `epc_out` keeps its value.
- R6: When level 1 is taken while `ps_in[4]` is clear, `pc_in` is saved in the level-1 slot of `epc_out`. `pc_out` is the user vector (offset 0x340) if `ps_in[5]` is set, or the kernel vector (offset 0x300) if it is clear.
- R7: With relocation enabled (the default), every vector address is `vec_base` plus the offset of that vector; with it disabled, the offset is added to the fixed default base 0x4000_0000.
- R8: When no interrupt is taken, `ps_out` equals `ps_in` and `pc_out` equals `pc_in` of the previous cycle, and `epc_out`, `eps_out`, `depc_out` and `exc_cause` keep their values.
- R9: `taken` is high for exactly the one cycle in which the dispatched `ps_out`, `pc_out` and save registers first appear. It is low in the next cycle unless a new request is taken.
- R10: While reset is applied, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | An interrupt request is offered this cycle |
| irq_level | input | 4 | Level of the pending interrupt |
| int_raised | input | NINT | Raised interrupt lines |
| int_enabled | input | NINT | Enabled interrupt lines |
| level_masks | input | NLEVEL*NINT | Lines belonging to each level; level L in slice L-1 |
| ps_in | input | XLEN | Current status word: [3:0] level, [4] exception mode, [5] user mode |
| pc_in | input | XLEN | Current program counter |
| vec_base | input | XLEN | Run-time vector base |
| ps_out | output | XLEN | Status word after dispatch |
| pc_out | output | XLEN | Next program counter |
| epc_out | output | NLEVEL*XLEN | Return addresses, level L in slice L-1 |
| eps_out | output | (NLEVEL-1)*XLEN | Saved status words, level L in slice L-2 |
| depc_out | output | XLEN | Double-exception return address |
| exc_cause | output | EXC_W | Exception cause code |
| taken | output | 1 | One-cycle pulse when an interrupt is dispatched |

## Verification
The hardest cases to reach are the rejection boundaries. These are a level equal to the current level, a level one past the configured count, and a raised line whose mask or enable bit is missing. Random stimulus seldom lands on these exact edges. Directed steps therefore place the level at each edge and clear single mask terms. The double-exception path needs the exception-mode flag set together with a level-1 request, and it must leave the level-1 return slot untouched. It is forced directly, and random status words also set that flag about half the time.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int LVL_W       = 4;
    localparam int PS_LVL_LSB  = 0;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;

    typedef enum logic [2:0] {
        PATH_NONE,
        PATH_HIGH,
        PATH_USER,
        PATH_KERNEL,
        PATH_DOUBLE
    } path_e;

    typedef struct packed {
        path_e             path;
        logic [LVL_W-1:0]  level;
    } decision_t;

    function automatic logic is_level1(input path_e p);
        return (p == PATH_USER) || (p == PATH_KERNEL) || (p == PATH_DOUBLE);
    endfunction

endpackage

// File: rtl/irq_decide.sv
module irq_decide
    import irq_dispatch_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NLEVEL = 6,
    parameter int NINT   = 32
) (
    input  logic                   req,
    input  logic [LVL_W-1:0]       level,
    input  logic [NINT-1:0]        raised,
    input  logic [NINT-1:0]        enabled,
    input  logic [NLEVEL*NINT-1:0] masks,
    input  logic [XLEN-1:0]        ps,
    output decision_t              dec
);
    logic [NINT-1:0] sel_mask;
    logic            above, in_range, hit, accept;

    always_comb begin
        sel_mask = '0;
        for (int l = 1; l <= NLEVEL; l++) begin
            if (level == LVL_W'(l)) sel_mask = masks[(l-1)*NINT +: NINT];
        end
    end

    assign above    = level > ps[PS_LVL_LSB +: LVL_W];
    assign in_range = 32'(level) <= NLEVEL;
    assign hit      = |(sel_mask & raised & enabled);
    assign accept   = req && above && in_range && hit;

    always_comb begin
        dec.level = level;
        if (!accept)               dec.path = PATH_NONE;
        else if (level > 4'd1)     dec.path = PATH_HIGH;
        else if (ps[PS_EXCM_BIT])  dec.path = PATH_DOUBLE;
        else if (ps[PS_UM_BIT])    dec.path = PATH_USER;
        else                       dec.path = PATH_KERNEL;
    end
endmodule

// File: rtl/irq_vector.sv
module irq_vector
    import irq_dispatch_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter bit              RELOC       = 1'b1,
    parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
    parameter logic [XLEN-1:0] HIGH_OFF    = 32'h180,
    parameter logic [XLEN-1:0] STRIDE      = 32'h40,
    parameter logic [XLEN-1:0] KERN_OFF    = 32'h300,
    parameter logic [XLEN-1:0] USER_OFF    = 32'h340,
    parameter logic [XLEN-1:0] DBL_OFF     = 32'h3C0
) (
    input  decision_t       dec,
    input  logic [XLEN-1:0] vec_base,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] offset, default_vec;

    always_comb begin
        unique case (dec.path)
            PATH_HIGH:   offset = HIGH_OFF + STRIDE * (XLEN'(dec.level) - XLEN'(2));
            PATH_USER:   offset = USER_OFF;
            PATH_DOUBLE: offset = DBL_OFF;
            default:     offset = KERN_OFF;
        endcase
    end

    assign default_vec = DEF_VECBASE + offset;

    generate
        if (RELOC) begin : g_reloc
            assign target = default_vec - DEF_VECBASE + vec_base;
        end else begin : g_fixed
            assign target = default_vec;
        end
    endgenerate
endmodule

// File: rtl/irq_savebank.sv
module irq_savebank
    import irq_dispatch_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NLEVEL   = 6,
    parameter bit HAS_DEPC = 1'b1,
    parameter int EXC_W    = 6,
    parameter int L1_CAUSE = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  decision_t                  dec,
    input  logic [XLEN-1:0]            pc_in,
    input  logic [XLEN-1:0]            ps_in,
    output logic [NLEVEL*XLEN-1:0]     epc_out,
    output logic [(NLEVEL-1)*XLEN-1:0] eps_out,
    output logic [XLEN-1:0]            depc_out,
    output logic [EXC_W-1:0]           exc_cause
);
    logic l1_to_epc;
    assign l1_to_epc = (dec.path == PATH_USER) || (dec.path == PATH_KERNEL) ||
                       ((dec.path == PATH_DOUBLE) && !HAS_DEPC);

    generate
        for (genvar l = 1; l <= NLEVEL; l++) begin : g_epc
            logic wr;
            if (l == 1) begin : g_one
                assign wr = l1_to_epc;
            end else begin : g_hi
                assign wr = (dec.path == PATH_HIGH) && (dec.level == LVL_W'(l));
            end
            always_ff @(posedge clk) begin
                if (rst)     epc_out[(l-1)*XLEN +: XLEN] <= '0;
                else if (wr) epc_out[(l-1)*XLEN +: XLEN] <= pc_in;
            end
        end

        for (genvar l = 2; l <= NLEVEL; l++) begin : g_eps
            always_ff @(posedge clk) begin
                if (rst)
                    eps_out[(l-2)*XLEN +: XLEN] <= '0;
                else if ((dec.path == PATH_HIGH) && (dec.level == LVL_W'(l)))
                    eps_out[(l-2)*XLEN +: XLEN] <= ps_in;
            end
        end

        if (HAS_DEPC) begin : g_depc
            always_ff @(posedge clk) begin
                if (rst)                          depc_out <= '0;
                else if (dec.path == PATH_DOUBLE) depc_out <= pc_in;
            end
        end else begin : g_nodepc
            assign depc_out = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                     exc_cause <= '0;
        else if (is_level1(dec.path)) exc_cause <= EXC_W'(L1_CAUSE);
    end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              NLEVEL      = 6,
    parameter int              NINT        = 32,
    parameter bit              HAS_DEPC    = 1'b1,
    parameter bit              RELOC       = 1'b1,
    parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
    parameter int              EXC_W       = 6,
    parameter int              L1_CAUSE    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       irq_req,
    input  logic [3:0]                 irq_level,
    input  logic [NINT-1:0]            int_raised,
    input  logic [NINT-1:0]            int_enabled,
    input  logic [NLEVEL*NINT-1:0]     level_masks,
    input  logic [XLEN-1:0]            ps_in,
    input  logic [XLEN-1:0]            pc_in,
    input  logic [XLEN-1:0]            vec_base,
    output logic [XLEN-1:0]            ps_out,
    output logic [XLEN-1:0]            pc_out,
    output logic [NLEVEL*XLEN-1:0]     epc_out,
    output logic [(NLEVEL-1)*XLEN-1:0] eps_out,
    output logic [XLEN-1:0]            depc_out,
    output logic [EXC_W-1:0]           exc_cause,
    output logic                       taken
);
    decision_t       dec;
    logic [XLEN-1:0] target, ps_next;

    irq_decide #(.XLEN(XLEN), .NLEVEL(NLEVEL), .NINT(NINT)) u_decide (
        .req(irq_req), .level(irq_level), .raised(int_raised),
        .enabled(int_enabled), .masks(level_masks), .ps(ps_in), .dec(dec)
    );

    irq_vector #(.XLEN(XLEN), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE)) u_vector (
        .dec(dec), .vec_base(vec_base), .target(target)
    );

    irq_savebank #(.XLEN(XLEN), .NLEVEL(NLEVEL), .HAS_DEPC(HAS_DEPC),
                   .EXC_W(EXC_W), .L1_CAUSE(L1_CAUSE)) u_save (
        .clk(clk), .rst(rst), .dec(dec), .pc_in(pc_in), .ps_in(ps_in),
        .epc_out(epc_out), .eps_out(eps_out), .depc_out(depc_out),
        .exc_cause(exc_cause)
    );

    always_comb begin
        ps_next = ps_in;
        if (dec.path == PATH_HIGH) begin
            ps_next[PS_LVL_LSB +: LVL_W] = dec.level;
            ps_next[PS_EXCM_BIT]         = 1'b1;
        end else if (is_level1(dec.path)) begin
            ps_next[PS_EXCM_BIT]         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_out <= '0;
            pc_out <= '0;
            taken  <= 1'b0;
        end else begin
            ps_out <= ps_next;
            pc_out <= (dec.path == PATH_NONE) ? pc_in : target;
            taken  <= dec.path != PATH_NONE;
        end
    end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int XLEN     = 32,
    parameter int NLEVEL   = 6,
    parameter int EXC_W    = 6,
    parameter int L1_CAUSE = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       irq_req,
    input logic [3:0]                 irq_level,
    input logic [XLEN-1:0]            ps_in,
    input logic [XLEN-1:0]            pc_in,
    input logic [XLEN-1:0]            ps_out,
    input logic [XLEN-1:0]            pc_out,
    input logic [NLEVEL*XLEN-1:0]     epc_out,
    input logic [(NLEVEL-1)*XLEN-1:0] eps_out,
    input logic [XLEN-1:0]            depc_out,
    input logic [EXC_W-1:0]           exc_cause,
    input logic                       taken
);
    logic primed;
    always_ff @(posedge clk) primed <= !rst;

    a_r1_take_gate: assert property (@(posedge clk) disable iff (rst)
        primed && taken |-> $past(irq_req) && (32'($past(irq_level)) <= NLEVEL)
                         && ($past(irq_level) > $past(ps_in[3:0])));

    a_r3_excm_after_take: assert property (@(posedge clk) disable iff (rst)
        primed && taken |-> ps_out[4]);

    a_r4_cause_code: assert property (@(posedge clk) disable iff (rst)
        primed && (exc_cause != $past(exc_cause)) |-> taken && (exc_cause == EXC_W'(L1_CAUSE)));

    a_r8_passthrough: assert property (@(posedge clk) disable iff (rst)
        primed && !taken |-> (ps_out == $past(ps_in)) && (pc_out == $past(pc_in)));

    a_r8_saves_hold: assert property (@(posedge clk) disable iff (rst)
        primed && !taken |-> $stable(epc_out) && $stable(eps_out) && $stable(depc_out));
endmodule

bind irq_dispatch irq_dispatch_chk #(
    .XLEN(XLEN), .NLEVEL(NLEVEL), .EXC_W(EXC_W), .L1_CAUSE(L1_CAUSE)
) u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_level(irq_level),
    .ps_in(ps_in), .pc_in(pc_in), .ps_out(ps_out), .pc_out(pc_out),
    .epc_out(epc_out), .eps_out(eps_out), .depc_out(depc_out),
    .exc_cause(exc_cause), .taken(taken)
);

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN   = 32;
    localparam int NLEVEL = 6;
    localparam int NINT   = 32;

    logic clk = 1'b0, rst = 1'b1, irq_req = 1'b0;
    logic [3:0] irq_level = '0;
    logic [NINT-1:0] int_raised = '0, int_enabled = '0;
    logic [NLEVEL*NINT-1:0] level_masks = '0;
    logic [XLEN-1:0] ps_in = '0, pc_in = '0, vec_base = '0;
    logic [XLEN-1:0] ps_out, pc_out, depc_out;
    logic [NLEVEL*XLEN-1:0] epc_out;
    logic [(NLEVEL-1)*XLEN-1:0] eps_out;
    logic [5:0] exc_cause;
    logic taken;

    irq_dispatch uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_level(irq_level),
        .int_raised(int_raised), .int_enabled(int_enabled), .level_masks(level_masks),
        .ps_in(ps_in), .pc_in(pc_in), .vec_base(vec_base),
        .ps_out(ps_out), .pc_out(pc_out), .epc_out(epc_out), .eps_out(eps_out),
        .depc_out(depc_out), .exc_cause(exc_cause), .taken(taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [XLEN-1:0] m_epc [1:NLEVEL];
    logic [XLEN-1:0] m_eps [2:NLEVEL];
    logic [XLEN-1:0] m_depc;
    logic [5:0]      m_cause;

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // 0 none, 1 high, 2 user, 3 kernel, 4 double
    function automatic int exp_path();
        logic [NINT-1:0] m;
        if (!irq_req || irq_level <= ps_in[3:0] || irq_level > NLEVEL || irq_level == 0) return 0;
        m = level_masks[(int'(irq_level)-1)*NINT +: NINT];
        if ((m & int_raised & int_enabled) == '0) return 0;
        if (irq_level > 1) return 1;
        if (ps_in[4]) return 4;
        return ps_in[5] ? 2 : 3;
    endfunction

    task automatic step(string extra);
        int p = exp_path();
        logic [XLEN-1:0] e_pc, e_ps;
        string tpc, tps;
        e_ps = ps_in; e_pc = pc_in; tpc = "R8"; tps = "R8";
        case (p)
            1: begin
                e_pc = vec_base + 32'h180 + 32'h40 * (32'(irq_level) - 2);
                e_ps[3:0] = irq_level; e_ps[4] = 1'b1;
                m_epc[int'(irq_level)] = pc_in; m_eps[int'(irq_level)] = ps_in;
                tpc = "R3"; tps = "R3";
            end
            2, 3: begin
                e_pc = vec_base + ((p == 2) ? 32'h340 : 32'h300);
                e_ps[4] = 1'b1; m_epc[1] = pc_in; m_cause = 6'd4;
                tpc = "R6"; tps = "R4";
            end
            4: begin
                e_pc = vec_base + 32'h3C0;
                e_ps[4] = 1'b1; m_depc = pc_in; m_cause = 6'd4;
                tpc = "R5"; tps = "R4";
            end
            default: ;
        endcase
        @(negedge clk);
        chk("R1", "taken", 32'(taken), 32'(p != 0));
        chk(tpc, "pc_out", pc_out, e_pc);
        chk(tps, "ps_out", ps_out, e_ps);
        for (int l = 1; l <= NLEVEL; l++) chk("R2", "epc", epc_out[(l-1)*XLEN +: XLEN], m_epc[l]);
        for (int l = 2; l <= NLEVEL; l++) chk("R2", "eps", eps_out[(l-2)*XLEN +: XLEN], m_eps[l]);
        chk("R5", "depc", depc_out, m_depc);
        chk("R4", "exc_cause", 32'(exc_cause), 32'(m_cause));
        if (extra != "") chk(extra, "pc_out", pc_out, e_pc);
    endtask

    task automatic set_req(logic [3:0] lv, logic [XLEN-1:0] ps, logic [XLEN-1:0] pc);
        irq_req = 1'b1; irq_level = lv; ps_in = ps; pc_in = pc;
        level_masks = '1; int_raised = 32'h1; int_enabled = 32'h1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 1; l <= NLEVEL; l++) m_epc[l] = '0;
        for (int l = 2; l <= NLEVEL; l++) m_eps[l] = '0;
        m_depc = '0; m_cause = '0;
        vec_base = 32'h2000_0000;
        @(negedge clk); @(negedge clk);
        // R10 reset state
        chk("R10", "ps_out", ps_out, '0);
        chk("R10", "pc_out", pc_out, '0);
        chk("R10", "taken", 32'(taken), '0);
        chk("R10", "epc", epc_out[XLEN-1:0], '0);
        rst = 1'b0;

        set_req(4'd3, 32'h0000_0101, 32'h1000_0010); step("");              // R2 R3
        set_req(4'd3, 32'h0000_0003, 32'h1000_0020); step("R1");            // equal level
        set_req(4'd7, 32'h0000_0000, 32'h1000_0030); step("R1");            // beyond NLEVEL
        set_req(4'd2, 32'h0, 32'h1000_0040); int_enabled = '0; step("R1");  // no enabled line
        set_req(4'd2, 32'h0, 32'h1000_0048); level_masks[NINT +: NINT] = '0; step("R1");
        set_req(4'd1, 32'h0000_0000, 32'h1000_0050); step("R6");            // kernel
        set_req(4'd1, 32'h0000_0020, 32'h1000_0060); step("R6");            // user
        set_req(4'd1, 32'h0000_0010, 32'h1000_0070); step("R5");            // double
        set_req(4'd2, 32'h0, 32'h1000_0080); irq_req = 1'b0; step("R1");    // no request
        set_req(4'd6, 32'h0000_0005, 32'h1000_0090); step("R3");            // top level
        vec_base = 32'h0000_8000;
        set_req(4'd2, 32'h0, 32'h1000_00A0); step("R7");
        vec_base = 32'h7FF0_0000;
        set_req(4'd2, 32'h0, 32'h1000_00B0); step("R7");
        // R9: taken pulse drops when the request goes away
        set_req(4'd4, 32'h0, 32'h1000_00C0); step("");
        irq_req = 1'b0; step("R8");
        chk("R9", "taken after pulse", 32'(taken), '0);

        for (int i = 0; i < 500; i++) begin
            irq_req     = ($urandom_range(0, 7) != 0);
            irq_level   = 4'($urandom_range(0, 8));
            for (int l = 0; l < NLEVEL; l++)
                level_masks[l*NINT +: NINT] = $urandom() & $urandom();
            int_raised  = $urandom() & $urandom();
            int_enabled = $urandom();
            ps_in       = $urandom();
            ps_in[3:0]  = 4'($urandom_range(0, 6));
            pc_in       = $urandom();
            vec_base    = $urandom() & 32'hFFFF_F000;
            step("");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule